// File: doc/BRIEF.md
# PCM Codec Serial Port with Frame Timing

This block sits between a companding codec's serial bus and a parallel processing core. Each frame it shifts in one 8-bit code on each of two serial lines, the send path and the receive path. When both codes are complete it presents them as bytes and raises a one-cycle load pulse. The same frame shifts two core-supplied bytes out onto two serial lines, each with its own output enable. Outside the 8-bit slot the enable is low, so the line can float. Every bus signal is sampled into the master clock domain and handled there by edge detection, so the block has a single clock.

The bit clock and frame sync can come from the external bus or from an internal generator. The generator divides the master clock down to a bit clock, and that bit clock down to a frame sync. A mode input selects which pair times the port. A falling edge on the start input launches frame processing in the core. For a fixed number of master cycles after reset release, those edges are ignored. Power-down floats the serial outputs, forces the generated clocks low, clears the port state and freezes the load pulse output.

Top module: `pcm_frame_port`

## Requirements
- R1: While `rst_n` is low, both output enables, both serial outputs, both generated clocks, `load_pulse`, `proc_start` and both capture bytes are 0.
- R2: Serial input bits are taken on bit clock falling edges, most significant bit first. Bit 7 is taken at the first falling edge for which the frame sync was high just before the edge. The next seven falling edges supply bits 6 down to 0.
- R3: `load_pulse` is high for exactly one master cycle per frame. It rises in the cycle in which both capture bytes take their new values, after bit 0.
- R4: At a bit clock rising edge for which the frame sync was high just before, both transmit bytes are latched, bit 7 appears on the outputs and both enables go high. Each of the following seven rising edges presents the next lower bit.
- R5: Both enables fall at the ninth rising edge of the frame and stay low until the next frame sync. A serial output whose enable is low reads 0.
- R6: The generated bit clock has a period of BIT_DIV master cycles and is high for its last BIT_DIV-BIT_DIV/2 cycles. The generated frame sync is high for one bit period in every FRAME_BITS bit periods and changes only together with a falling bit clock.
- R7: With `int_timing` high, the port is timed by the generated clocks and the external bit clock and frame sync are ignored.
- R8: A falling edge on `start_n` gives a one-cycle `proc_start` pulse, except during the first BLANK_CYCLES master cycles after reset release, when it gives none.
- R9: While `pd_n` is low, both enables, both generated clocks and `proc_start` are low and the capture bytes read 0.
- R10: The port transfers correctly with any external bit clock half-period of five or more master cycles.
- R11: Bits after the eighth in a frame are ignored: they change neither capture byte and produce no further `load_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_n | input | 1 | Power-down when low |
| int_timing | input | 1 | 1: use the generated bit clock and frame sync |
| bclk_in | input | 1 | External bit clock |
| fsync_in | input | 1 | External frame sync |
| snd_din | input | 1 | Send-path serial input |
| rcv_din | input | 1 | Receive-path serial input |
| start_n | input | 1 | Frame processing start, falling-edge active |
| snd_tx | input | 8 | Byte to transmit on the send path |
| rcv_tx | input | 8 | Byte to transmit on the receive path |
| snd_dout | output | 1 | Send-path serial output |
| snd_oe | output | 1 | Send-path output enable |
| rcv_dout | output | 1 | Receive-path serial output |
| rcv_oe | output | 1 | Receive-path output enable |
| bclk_gen | output | 1 | Generated bit clock |
| fsync_gen | output | 1 | Generated frame sync |
| load_pulse | output | 1 | Both bytes captured |
| proc_start | output | 1 | Frame processing launch pulse |
| snd_cap | output | 8 | Captured send-path byte |
| rcv_cap | output | 8 | Captured receive-path byte |

## Verification
The bench builds the port with BIT_DIV=10, FRAME_BITS=12 and BLANK_CYCLES=300 in place of the full-rate divide ratios and the long blanking count. These values let the blanking window both expire and be tested inside it in a few hundred cycles. They also make a full generated frame of 120 cycles short enough to measure edge by edge. External frames use random half-periods from five to twenty master cycles and lengths from eight to eleven bits, so the shortest legal bit time and overlong frames both occur.

// File: rtl/pcm_frame_port.sv
`timescale 1ns/1ps
module pcm_frame_port #(
  parameter int BIT_DIV      = 75,
  parameter int FRAME_BITS   = 32,
  parameter int BLANK_CYCLES = 1_920_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_n,
  input  logic       int_timing,
  input  logic       bclk_in,
  input  logic       fsync_in,
  input  logic       snd_din,
  input  logic       rcv_din,
  input  logic       start_n,
  input  logic [7:0] snd_tx,
  input  logic [7:0] rcv_tx,
  output logic       snd_dout,
  output logic       snd_oe,
  output logic       rcv_dout,
  output logic       rcv_oe,
  output logic       bclk_gen,
  output logic       fsync_gen,
  output logic       load_pulse,
  output logic       proc_start,
  output logic [7:0] snd_cap,
  output logic [7:0] rcv_cap
);
  localparam int HALF = BIT_DIV / 2;
  localparam int DW   = $clog2(BIT_DIV);
  localparam int FW   = $clog2(FRAME_BITS);
  localparam int BW   = $clog2(BLANK_CYCLES + 1);

  logic [DW-1:0] div_cnt;
  logic [FW-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !pd_n) begin
      div_cnt <= '0;
      bit_cnt <= FW'(FRAME_BITS - 1);
    end else if (div_cnt == DW'(BIT_DIV - 1)) begin
      div_cnt <= '0;
      bit_cnt <= (bit_cnt == FW'(FRAME_BITS - 1)) ? '0 : bit_cnt + FW'(1);
    end else begin
      div_cnt <= div_cnt + DW'(1);
    end
  end

  assign bclk_gen  = pd_n && (div_cnt >= DW'(HALF));
  assign fsync_gen = pd_n && (bit_cnt == '0);

  logic raw_bclk, raw_fsync;
  assign raw_bclk  = int_timing ? bclk_gen  : bclk_in;
  assign raw_fsync = int_timing ? fsync_gen : fsync_in;

  logic [2:0] bclk_q, fsync_q, snd_q, rcv_q, start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= '0; fsync_q <= '0; snd_q <= '0; rcv_q <= '0; start_q <= '1;
    end else if (!pd_n) begin
      bclk_q <= '0; fsync_q <= '0; snd_q <= '0; rcv_q <= '0; start_q <= '1;
    end else begin
      bclk_q  <= {bclk_q[1:0],  raw_bclk};
      fsync_q <= {fsync_q[1:0], raw_fsync};
      snd_q   <= {snd_q[1:0],   snd_din};
      rcv_q   <= {rcv_q[1:0],   rcv_din};
      start_q <= {start_q[1:0], start_n};
    end
  end

  logic bclk_fall, bclk_rise, mark;
  assign bclk_fall = bclk_q[2] & ~bclk_q[1];
  assign bclk_rise = ~bclk_q[2] & bclk_q[1];
  assign mark      = fsync_q[2];

  logic [6:0] snd_acc, rcv_acc;
  logic [2:0] rcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snd_acc <= '0; rcv_acc <= '0; rcnt <= '0;
      snd_cap <= '0; rcv_cap <= '0; load_pulse <= 1'b0;
    end else if (!pd_n) begin
      snd_acc <= '0; rcv_acc <= '0; rcnt <= '0;
      snd_cap <= '0; rcv_cap <= '0;
    end else begin
      load_pulse <= 1'b0;
      if (bclk_fall) begin
        if (mark) begin
          snd_acc <= {snd_acc[5:0], snd_q[2]};
          rcv_acc <= {rcv_acc[5:0], rcv_q[2]};
          rcnt    <= 3'd1;
        end else if (rcnt != 3'd0) begin
          if (rcnt == 3'd7) begin
            snd_cap    <= {snd_acc, snd_q[2]};
            rcv_cap    <= {rcv_acc, rcv_q[2]};
            load_pulse <= 1'b1;
            rcnt       <= 3'd0;
          end else begin
            snd_acc <= {snd_acc[5:0], snd_q[2]};
            rcv_acc <= {rcv_acc[5:0], rcv_q[2]};
            rcnt    <= rcnt + 3'd1;
          end
        end
      end
    end
  end

  logic [7:0] snd_sh, rcv_sh;
  logic [3:0] tcnt;
  logic       tx_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !pd_n) begin
      snd_sh <= '0; rcv_sh <= '0; tcnt <= '0; tx_on <= 1'b0;
    end else if (bclk_rise) begin
      if (mark) begin
        snd_sh <= snd_tx;
        rcv_sh <= rcv_tx;
        tx_on  <= 1'b1;
        tcnt   <= 4'd1;
      end else if (tcnt != 4'd0) begin
        if (tcnt == 4'd8) begin
          tx_on <= 1'b0;
          tcnt  <= 4'd0;
        end else begin
          snd_sh <= {snd_sh[6:0], 1'b0};
          rcv_sh <= {rcv_sh[6:0], 1'b0};
          tcnt   <= tcnt + 4'd1;
        end
      end
    end
  end

  assign snd_oe   = tx_on & pd_n;
  assign rcv_oe   = tx_on & pd_n;
  assign snd_dout = snd_oe & snd_sh[7];
  assign rcv_dout = rcv_oe & rcv_sh[7];

  logic [BW-1:0] blank_cnt;
  logic          start_armed;
  logic          go_q;

  assign start_armed = (blank_cnt == BW'(BLANK_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !pd_n) begin
      blank_cnt <= '0;
      go_q      <= 1'b0;
    end else begin
      if (!start_armed) blank_cnt <= blank_cnt + BW'(1);
      go_q <= start_q[2] & ~start_q[1] & start_armed;
    end
  end

  assign proc_start = go_q;
endmodule

// File: rtl/pcm_frame_port_chk.sv
`timescale 1ns/1ps
module pcm_frame_port_chk (
  input logic clk,
  input logic rst_n,
  input logic pd_n,
  input logic snd_oe,
  input logic rcv_oe,
  input logic bclk_gen,
  input logic fsync_gen,
  input logic load_pulse,
  input logic proc_start,
  input logic start_armed
);
  assert_pd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |-> (!snd_oe && !rcv_oe && !bclk_gen && !fsync_gen));

  assert_load_single_R3: assert property (@(posedge clk) disable iff (!rst_n || !pd_n)
    load_pulse |=> !load_pulse);

  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n || !pd_n)
    proc_start |=> !proc_start);

  assert_start_armed_R8: assert property (@(posedge clk) disable iff (!rst_n || !pd_n)
    proc_start |-> start_armed);

  assert_sync_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n || !pd_n)
    !$stable(fsync_gen) |-> $fell(bclk_gen));
endmodule

bind pcm_frame_port pcm_frame_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .snd_oe(snd_oe), .rcv_oe(rcv_oe),
  .bclk_gen(bclk_gen), .fsync_gen(fsync_gen), .load_pulse(load_pulse),
  .proc_start(proc_start), .start_armed(start_armed)
);

// File: tb/pcm_frame_port_tb.sv
`timescale 1ns/1ps
module pcm_frame_port_tb;
  localparam int BD = 10;
  localparam int FB = 12;
  localparam int BL = 300;

  logic clk = 1'b0;
  logic rst_n, pd_n, int_timing, bclk_in, fsync_in, snd_din, rcv_din, start_n;
  logic [7:0] snd_tx, rcv_tx;
  logic snd_dout, snd_oe, rcv_dout, rcv_oe, bclk_gen, fsync_gen, load_pulse, proc_start;
  logic [7:0] snd_cap, rcv_cap;

  int checks = 0;
  int errors = 0;
  int lp_cnt = 0;
  int ps_cnt = 0;

  always #10 clk = ~clk;

  pcm_frame_port #(.BIT_DIV(BD), .FRAME_BITS(FB), .BLANK_CYCLES(BL)) u_dut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .int_timing(int_timing),
    .bclk_in(bclk_in), .fsync_in(fsync_in), .snd_din(snd_din), .rcv_din(rcv_din),
    .start_n(start_n), .snd_tx(snd_tx), .rcv_tx(rcv_tx),
    .snd_dout(snd_dout), .snd_oe(snd_oe), .rcv_dout(rcv_dout), .rcv_oe(rcv_oe),
    .bclk_gen(bclk_gen), .fsync_gen(fsync_gen), .load_pulse(load_pulse),
    .proc_start(proc_start), .snd_cap(snd_cap), .rcv_cap(rcv_cap)
  );

  always @(posedge clk) begin
    if (load_pulse) lp_cnt++;
    if (proc_start) ps_cnt++;
  end

  function automatic logic exp_oe(input int i);
    return i < 8;
  endfunction

  function automatic logic exp_bit(input logic [7:0] b, input int i);
    if (i < 8) return b[7 - i];
    return 1'b0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ext_frame(input logic [7:0] s_in, input logic [7:0] r_in,
                           input logic [7:0] s_tx, input logic [7:0] r_tx,
                           input int half, input int nbits);
    int lp0;
    lp0 = lp_cnt;
    snd_tx = s_tx;
    rcv_tx = r_tx;
    for (int i = 0; i < nbits; i++) begin
      bclk_in = 1'b0;
      @(negedge clk);
      fsync_in = (i == 0);
      repeat (half - 1) @(negedge clk);
      bclk_in = 1'b1;
      snd_din = (i < 8) ? exp_bit(s_in, i) : 1'($urandom);
      rcv_din = (i < 8) ? exp_bit(r_in, i) : 1'($urandom);
      repeat (half - 1) @(negedge clk);
      chk((i < 8) ? "R4 snd_oe" : "R5 snd_oe", snd_oe, exp_oe(i));
      chk((i < 8) ? "R4 rcv_oe" : "R5 rcv_oe", rcv_oe, exp_oe(i));
      chk((i < 8) ? "R4 snd_dout" : "R5 snd_dout", snd_dout, exp_bit(s_tx, i));
      chk((i < 8) ? "R4 rcv_dout" : "R5 rcv_dout", rcv_dout, exp_bit(r_tx, i));
      @(negedge clk);
    end
    bclk_in = 1'b0;
    repeat (8) @(negedge clk);
    chk("R2 snd_cap", snd_cap, s_in);
    chk("R2 rcv_cap", rcv_cap, r_in);
    chk((nbits > 8) ? "R11 load count" : "R3 load count", lp_cnt - lp0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    int lp0;
    logic [7:0] a, b, c, d;
    void'($urandom(32'd4242));
    rst_n = 1'b0; pd_n = 1'b1; int_timing = 1'b0; bclk_in = 1'b0; fsync_in = 1'b0;
    snd_din = 1'b0; rcv_din = 1'b0; start_n = 1'b1; snd_tx = 8'h00; rcv_tx = 8'h00;
    repeat (4) @(negedge clk);
    chk("R1 snd_oe", snd_oe, 0);
    chk("R1 rcv_oe", rcv_oe, 0);
    chk("R1 douts", {snd_dout, rcv_dout}, 0);
    chk("R1 gen clocks", {bclk_gen, fsync_gen}, 0);
    chk("R1 pulses", {load_pulse, proc_start}, 0);
    chk("R1 caps", {snd_cap, rcv_cap}, 0);

    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    start_n = 1'b0; repeat (3) @(negedge clk); start_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 blanked start", ps_cnt, 0);
    repeat (BL) @(negedge clk);
    start_n = 1'b0; repeat (3) @(negedge clk); start_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 armed start", ps_cnt, 1);

    ext_frame(8'hA5, 8'h3C, 8'h96, 8'h5A, 5, 8);
    chk("R10 shortest half-period", snd_cap, 8'hA5);
    ext_frame(8'h00, 8'hFF, 8'hFF, 8'h00, 20, 8);
    chk("R10 long half-period", rcv_cap, 8'hFF);
    ext_frame(8'h81, 8'h7E, 8'h01, 8'h80, 6, 11);
    ext_frame(8'h5A, 8'hC3, 8'hE7, 8'h18, 5, 8);

    for (int k = 0; k < 14; k++) begin
      a = 8'($urandom); b = 8'($urandom); c = 8'($urandom); d = 8'($urandom);
      ext_frame(a, b, c, d, 5 + int'($urandom % 16), 8 + int'($urandom % 4));
    end

    snd_tx = 8'hC0; rcv_tx = 8'h40;
    bclk_in = 1'b0;
    @(negedge clk); fsync_in = 1'b1;
    repeat (5) @(negedge clk);
    bclk_in = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 oe before power-down", snd_oe, 1);
    lp0 = lp_cnt;
    pd_n = 1'b0;
    @(negedge clk);
    chk("R9 snd_oe", snd_oe, 0);
    chk("R9 rcv_oe", rcv_oe, 0);
    chk("R9 douts", {snd_dout, rcv_dout}, 0);
    repeat (30) @(negedge clk);
    chk("R9 gen clocks", {bclk_gen, fsync_gen}, 0);
    chk("R9 caps", {snd_cap, rcv_cap}, 0);
    start_n = 1'b0; repeat (4) @(negedge clk); start_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 proc_start", ps_cnt, 1);
    chk("R9 no load", lp_cnt - lp0, 0);
    fsync_in = 1'b0; bclk_in = 1'b0;
    pd_n = 1'b1;
    do_reset();

    int_timing = 1'b1;
    snd_tx = 8'h6D; rcv_tx = 8'hB2;
    do_reset();
    while (!fsync_gen) @(negedge clk);
    n = 0;
    while (fsync_gen) begin @(negedge clk); n++; end
    chk("R6 fsync high length", n, BD);
    n = 0;
    while (!fsync_gen) begin @(negedge clk); n++; end
    chk("R6 fsync low length", n, BD * FB - BD);
    while (!bclk_gen) @(negedge clk);
    n = 0;
    while (bclk_gen) begin @(negedge clk); n++; end
    chk("R6 bclk high length", n, BD - BD / 2);
    n = 0;
    while (!bclk_gen) begin @(negedge clk); n++; end
    chk("R6 bclk low length", n, BD / 2);

    bclk_in = 1'b1; fsync_in = 1'b1;
    while (fsync_gen) @(negedge clk);
    while (!fsync_gen) @(negedge clk);
    lp0 = lp_cnt;
    for (int i = 0; i < 8; i++) begin
      while (!bclk_gen) @(negedge clk);
      snd_din = exp_bit(8'h4E, i);
      rcv_din = exp_bit(8'hD1, i);
      while (bclk_gen) @(negedge clk);
      chk("R7 snd_dout", snd_dout, exp_bit(8'h6D, i));
      chk("R7 rcv_dout", rcv_dout, exp_bit(8'hB2, i));
    end
    repeat (6) @(negedge clk);
    chk("R7 snd_cap", snd_cap, 8'h4E);
    chk("R7 rcv_cap", rcv_cap, 8'hD1);
    chk("R7 load count", lp_cnt - lp0, 1);

    summary();
    $finish;
  end
endmodule